// File: doc/BRIEF.md
# Low-Power Mode Clock Enable Controller

This block sits beside a small 16-bit processor core and decides, from four status-register control bits, which of four clock domains may toggle. The domains are the fast oscillator, the main processor clock, the peripheral clock and the slow auxiliary clock. The bits are a processor-halt bit, a fast-oscillator-off bit, a peripheral-clock-off bit and a slow-oscillator-off bit. The usual combinations give five named sleep levels. Level 0 sets only the halt bit. Level 1 adds the fast-oscillator-off bit. Level 2 adds the peripheral-clock-off bit. Level 3 adds both of those. Level 4 adds the slow-oscillator-off bit as well.

External wakeup lines are resynchronised to the controller clock and turned into interrupt requests. While an interrupt is serviced, the controller ignores all four bits, so every domain is running. After the return-from-interrupt pulse, the bits are obeyed again. If the handler left them in place, the old sleep level comes back. If it cleared them, the core stays active. The block is synchronous enable logic. Each enable is registered, so it can drive a gating cell directly.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it, all four enables are 1, every interrupt request is 0 and `smclk_src_lf` follows `smclk_sel_lf`.
- R2: With the halt bit set and no interrupt pending, `mclk_en` is 0. The halt bit alone leaves `dco_en` and `smclk_en` at 1.
- R3: With the fast-oscillator-off bit set and no interrupt pending, `dco_en` is 0 and `smclk_src_lf` is 1, so the peripheral clock runs from the slow oscillator.
- R4: With the peripheral-clock-off bit set, `smclk_en` is 0 when parameter `SCG1_EN` is 1. When `SCG1_EN` is 0, the bit has no effect.
- R5: With the slow-oscillator-off bit set and parameter `OSCOFF_EN` at 1, `aclk_en` is 0. `smclk_en` is also 0 whenever `smclk_src_lf` is 1.
- R6: A wakeup line sampled high at a clock edge shows on its `irq_req` bit after the second following edge (two-flop synchroniser).
- R7: From two edges after any `irq_req` bit is 1, until `reti` is seen with no request pending, all four enables are 1 whatever the status bits.
- R8: Two edges after `reti` with no request pending, the enables follow the status bits present at that time. This re-enters the earlier level, or stays active if the bits were cleared.
- R9: `smclk_src_lf` is 1 when `smclk_sel_lf` is 1, or when the fast-oscillator-off bit is in effect. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (free running) |
| rst | input | 1 | Synchronous peripheral reset, active high |
| cpu_off | input | 1 | Status bit: halt processor clock |
| scg0 | input | 1 | Status bit: stop fast oscillator |
| scg1 | input | 1 | Status bit: stop peripheral clock |
| osc_off | input | 1 | Status bit: stop slow oscillator |
| smclk_sel_lf | input | 1 | Configured peripheral clock source, 1 = slow oscillator |
| wkup | input | NWK | Asynchronous wakeup requests |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | NWK | Synchronised interrupt requests |
| dco_en | output | 1 | Fast oscillator enable |
| mclk_en | output | 1 | Main processor clock enable |
| smclk_en | output | 1 | Peripheral clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| smclk_src_lf | output | 1 | Peripheral clock source in use, 1 = slow oscillator |

## Verification
The properties assume three things about the inputs. Reset is asserted at time zero. The status bits are stable around the clock edge. `reti` comes only after a request has gone away, because a pending request re-arms the override. The stimulus changes every input on the falling edge. Each wakeup is held until its request has been seen, and then dropped for several cycles before `reti` is pulsed. Random status combinations and source selections are mixed with directed handler-exit cases, where the bits are either kept or cleared.

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl #(
  parameter int NWK       = 2,
  parameter bit SCG1_EN   = 1'b1,
  parameter bit OSCOFF_EN = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cpu_off,
  input  logic           scg0,
  input  logic           scg1,
  input  logic           osc_off,
  input  logic           smclk_sel_lf,
  input  logic [NWK-1:0] wkup,
  input  logic           reti,
  output logic [NWK-1:0] irq_req,
  output logic           dco_en,
  output logic           mclk_en,
  output logic           smclk_en,
  output logic           aclk_en,
  output logic           smclk_src_lf
);

  logic [NWK-1:0] wk_s1, wk_s2;
  logic           ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wk_s1 <= '0;
      wk_s2 <= '0;
    end else begin
      wk_s1 <= wkup;
      wk_s2 <= wk_s1;
    end
  end

  assign irq_req = wk_s2;

  always_ff @(posedge clk) begin
    if (rst) ovr_q <= 1'b0;
    else     ovr_q <= (|wk_s2) | (ovr_q & ~reti);
  end

  logic e_off, e_scg0, e_scg1, e_osc;
  assign e_off  = cpu_off & ~ovr_q;
  assign e_scg0 = scg0    & ~ovr_q;
  assign e_scg1 = scg1    & ~ovr_q & SCG1_EN;
  assign e_osc  = osc_off & ~ovr_q & OSCOFF_EN;

  logic src_lf_d, aclk_d, dco_d;
  assign src_lf_d = smclk_sel_lf | e_scg0;
  assign aclk_d   = ~e_osc;
  assign dco_d    = ~e_scg0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dco_en       <= 1'b1;
      mclk_en      <= 1'b1;
      smclk_en     <= 1'b1;
      aclk_en      <= 1'b1;
      smclk_src_lf <= smclk_sel_lf;
    end else begin
      dco_en       <= dco_d;
      mclk_en      <= ~e_off;
      smclk_en     <= ~e_scg1 & (src_lf_d ? aclk_d : dco_d);
      aclk_en      <= aclk_d;
      smclk_src_lf <= src_lf_d;
    end
  end

endmodule

module lpm_clk_ctrl_chk #(
  parameter int NWK = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           cpu_off,
  input logic           scg0,
  input logic           osc_off,
  input logic [NWK-1:0] wkup,
  input logic [NWK-1:0] irq_req,
  input logic           dco_en,
  input logic           mclk_en,
  input logic           aclk_en
);

  assert_reset_on_R1: assert property (@(posedge clk)
    rst |=> (dco_en && mclk_en && aclk_en && irq_req == '0));

  assert_mclk_off_cause_R2: assert property (@(posedge clk) disable iff (rst)
    !mclk_en |-> $past(cpu_off));

  assert_dco_off_cause_R3: assert property (@(posedge clk) disable iff (rst)
    !dco_en |-> $past(scg0));

  assert_aclk_off_cause_R5: assert property (@(posedge clk) disable iff (rst)
    !aclk_en |-> $past(osc_off));

  assert_wake_restores_R7: assert property (@(posedge clk) disable iff (rst)
    (|irq_req) |=> ##1 (dco_en && mclk_en));

  for (genvar i = 0; i < NWK; i++) begin : g_sync
    assert_sync_depth_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_req[i]) |-> $past(wkup[i], 2));
  end

endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.NWK(NWK)) u_chk (
  .clk(clk), .rst(rst), .cpu_off(cpu_off), .scg0(scg0), .osc_off(osc_off),
  .wkup(wkup), .irq_req(irq_req), .dco_en(dco_en), .mclk_en(mclk_en),
  .aclk_en(aclk_en)
);

// File: tb/lpm_clk_ctrl_test.sv
module lpm_clk_ctrl_test;
  localparam int PERIOD = 10;
  localparam int NWK = 2;

  logic clk = 0, rst = 1;
  logic cpu_off = 0, scg0 = 0, scg1 = 0, osc_off = 0, sel_lf = 0, reti = 0;
  logic [NWK-1:0] wkup = '0;
  logic [NWK-1:0] irq_req;
  logic dco_en, mclk_en, smclk_en, aclk_en, src_lf;
  int checks = 0, failures = 0;

  always #(PERIOD/2) clk = ~clk;

  lpm_clk_ctrl #(.NWK(NWK), .SCG1_EN(1'b1), .OSCOFF_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .cpu_off(cpu_off), .scg0(scg0), .scg1(scg1),
    .osc_off(osc_off), .smclk_sel_lf(sel_lf), .wkup(wkup), .reti(reti),
    .irq_req(irq_req), .dco_en(dco_en), .mclk_en(mclk_en),
    .smclk_en(smclk_en), .aclk_en(aclk_en), .smclk_src_lf(src_lf));

  // expected {dco, mclk, smclk, aclk, src_lf}
  function automatic logic [4:0] model(input logic ovr, input logic c, input logic s0,
                                       input logic s1, input logic o, input logic sl);
    logic d, m, sm, a, lf;
    d  = ~(s0 & ~ovr);
    m  = ~(c & ~ovr);
    a  = ~(o & ~ovr);
    lf = sl | (s0 & ~ovr);
    sm = ~(s1 & ~ovr) & (lf ? a : d);
    return {d, m, sm, a, lf};
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [4:0] outs();
    return {dco_en, mclk_en, smclk_en, aclk_en, src_lf};
  endfunction

  task automatic set_bits(input logic [4:0] b);
    {cpu_off, scg0, scg1, osc_off, sel_lf} = b;
  endtask

  task automatic wake_cycle(input int line, input bit clear_in_handler, input string req);
    logic [4:0] b;
    b = {cpu_off, scg0, scg1, osc_off, sel_lf};
    wkup[line] = 1'b1;
    cyc(1);
    chk("R6 one edge", {4'b0, irq_req[line]}, 5'b0);
    cyc(1);
    chk("R6 two edges", {4'b0, irq_req[line]}, 5'b1);
    cyc(2);
    chk("R7 override", outs(), model(1'b1, b[4], b[3], b[2], b[1], b[0]));
    wkup[line] = 1'b0;
    cyc(4);
    chk("R7 held", outs(), 5'b11110 | {4'b0, b[0]});
    if (clear_in_handler) begin
      set_bits({4'b0, b[0]});
      b = {4'b0, b[0]};
    end
    reti = 1'b1;
    cyc(1);
    reti = 1'b0;
    cyc(2);
    chk(req, outs(), model(1'b0, b[4], b[3], b[2], b[1], b[0]));
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    cyc(3);
    chk("R1 reset", outs(), 5'b11110);
    chk("R1 irq", {3'b0, irq_req}, 5'b0);
    rst = 0;
    cyc(1);
    chk("R1 after reset", outs(), 5'b11110);

    // directed sleep levels 0..4
    set_bits(5'b10000); cyc(2); chk("R2 halt only", outs(), 5'b10110);
    set_bits(5'b11000); cyc(2); chk("R3 fast off", outs(), 5'b00111);
    set_bits(5'b10100); cyc(2); chk("R4 periph off", outs(), 5'b10010);
    set_bits(5'b11100); cyc(2); chk("R4 level3", outs(), 5'b00011);
    set_bits(5'b11110); cyc(2); chk("R5 level4", outs(), 5'b00001);
    set_bits(5'b00011); cyc(2); chk("R5 slow off lf src", outs(), 5'b11001);
    set_bits(5'b00001); cyc(2); chk("R9 sel lf", outs(), 5'b11111);

    // random static combinations
    for (int i = 0; i < 40; i++) begin
      logic [4:0] b;
      b = 5'($urandom);
      set_bits(b);
      cyc(2);
      chk("R9 random", outs(), model(1'b0, b[4], b[3], b[2], b[1], b[0]));
    end

    // handler exits
    set_bits(5'b10000); cyc(2); wake_cycle(0, 1'b0, "R8 reenter level0");
    set_bits(5'b11100); cyc(2); wake_cycle(1, 1'b0, "R8 reenter level3");
    set_bits(5'b11110); cyc(2); wake_cycle(0, 1'b1, "R8 cleared active");
    for (int i = 0; i < 12; i++) begin
      logic [4:0] b;
      b = 5'($urandom) | 5'b10000;
      set_bits(b);
      cyc(2);
      wake_cycle(i % NWK, 1'($urandom), "R8 random exit");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule